// File: doc/BRIEF.md
# Card slot status and interrupt register

This block is a small register file that sits beside a removable-card slot. It shows the slot's write-protect switch as a live status bit and turns a card-insertion pulse into a latched event. While that event is pending, the block holds an interrupt line high. Software reads the status word to learn the slot state. It acknowledges the insertion by writing a one to the event bit of that same word.

The register bus carries a request strobe, a write flag, a word index, write data and combinational read data. Four word indices are decoded:

- Index 0 returns a fixed identification word.
- Index 1 is a flash-programming word. It reads as zero and ignores writes.
- Index 2 is the status/interrupt word.
- Index 3 returns a fixed decode word and ignores writes.

Any request above index 3 reads as zero and raises a sticky bus-error flag.

Top module: `cdet_slot_regs`

## Requirements
- R1: A synchronous active-low reset clears the card-insert event bit, deasserts `slot_irq` and clears `bus_err`. Reset takes priority over a high `card_in`.
- R2: A read of index 0 returns 0x41034003, a read of index 1 returns 0, and a read of index 3 returns 0x00000011. Read data appears in the same cycle as the request. Read data is 0 when there is no read request.
- R3: Bit 0 of the index-2 word equals the current level of `wp_in`, with no clock delay.
- R4: `card_in` high at a rising clock edge sets bit 3 of the index-2 word and asserts `slot_irq` from that edge on. `card_in` returning low does not clear the bit.
- R5: A write to index 2 whose data has bit 3 set clears bit 3 and deasserts `slot_irq` at that edge. A write whose data has bit 3 clear leaves bit 3 unchanged.
- R6: Every bit of the index-2 word other than bits 0 and 3 reads as 0. Writing ones to those bits has no effect on the word or on `slot_irq`.
- R7: Writes to index 1 and index 3 change no readable value, do not touch bit 3 or `slot_irq`, and do not set `bus_err`.
- R8: When `card_in` is high in the same cycle as a clearing write to index 2, the set wins: bit 3 and `slot_irq` are 1 after the edge.
- R9: A request of either kind with index greater than 3 reads as 0 and sets `bus_err` at that edge. `bus_err` stays set until reset.
- R10: `slot_irq` always equals bit 3 of the index-2 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the request cycle |
| wp_in | input | 1 | Write-protect switch level |
| card_in | input | 1 | Card-insertion event, sampled each edge |
| slot_irq | output | 1 | High while the insertion event is pending |
| bus_err | output | 1 | Sticky flag for an out-of-range access |

## Verification
Two events can land on the event bit in the same clock edge: a card-insertion pulse and a software acknowledge write. The bench provokes this by driving `card_in` high in the very cycle of a write to index 2 with bit 3 set. After that edge it expects `slot_irq` to be high and bit 3 to read back as 1. A plain acknowledge in the next step must then bring both low, which shows the collision left no hidden state behind.

// File: rtl/cdet_pkg.sv
// Package: shared constants and types for the card slot register block.
// Assumes the word map is fixed at four decoded indices.
package cdet_pkg;
    localparam int IX_IDENT    = 0;
    localparam int IX_FLASHPRG = 1;
    localparam int IX_STATUS   = 2;
    localparam int IX_DECODE   = 3;
    localparam int IX_LAST     = IX_DECODE;

    localparam int WP_POS  = 0;   // live write-protect bit in the status word
    localparam int INS_POS = 3;   // sticky insertion bit in the status word

    typedef struct packed {
        logic rd_ident;
        logic rd_status;
        logic rd_decode;
        logic wr_status;
    } dec_t;
endpackage

// File: rtl/cdet_decode.sv
// Module: index decoder and sticky out-of-range error flag.
// Assumes one access per cycle; index 1 reads need no select (they read zero).
module cdet_decode
    import cdet_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec,
    output logic             err_o
);
    logic oob;
    logic err_q;

    // Decode the index into read/write selects.
    always_comb begin
        dec.rd_ident  = req && !wr && (idx == IDX_W'(IX_IDENT));
        dec.rd_status = req && !wr && (idx == IDX_W'(IX_STATUS));
        dec.rd_decode = req && !wr && (idx == IDX_W'(IX_DECODE));
        dec.wr_status = req &&  wr && (idx == IDX_W'(IX_STATUS));
        oob           = req && (idx > IDX_W'(IX_LAST));
    end

    // Hold the bus-error flag once any out-of-range access is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (oob)
            err_q <= 1'b1;
    end

    assign err_o = err_q;
endmodule

// File: rtl/cdet_event.sv
// Module: per-bit sticky event latches with write-one-to-clear.
// Assumes STICKY_MASK marks which bits hold an event; other bits stay zero.
// A set and a clear in the same cycle leave the bit set.
module cdet_event #(
    parameter int              DATA_W      = 32,
    parameter logic [DATA_W-1:0] STICKY_MASK = DATA_W'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_ev,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] sticky,
    output logic              pending
);
    logic [DATA_W-1:0] clr_vec;

    // Qualify the clear data with the write strobe and the sticky mask.
    always_comb clr_vec = clr_en ? (clr_data & STICKY_MASK) : '0;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (STICKY_MASK[b]) begin : g_flop
            logic q;
            // Latch the event; a set beats a same-cycle clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (set_ev[b])
                    q <= 1'b1;
                else if (clr_vec[b])
                    q <= 1'b0;
            end
            assign sticky[b] = q;
        end else begin : g_zero
            assign sticky[b] = 1'b0;
        end
    end

    assign pending = |sticky;
endmodule

// File: rtl/cdet_rdmux.sv
// Module: combinational read-data selector.
// Assumes the selects are mutually exclusive; no select returns zero.
module cdet_rdmux
    import cdet_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_WORD  = DATA_W'(32'h4103_4003),
    parameter logic [DATA_W-1:0] DEC_WORD = DATA_W'(32'h11)
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    // Pick the word for the current read.
    always_comb begin
        if (dec.rd_ident)
            rdata = ID_WORD;
        else if (dec.rd_status)
            rdata = status;
        else if (dec.rd_decode)
            rdata = DEC_WORD;
        else
            rdata = '0;
    end
endmodule

// File: rtl/cdet_slot_regs.sv
// Module: card slot status/interrupt register block (top).
// Assumes wp_in and card_in are already synchronous to clk and debounced.
module cdet_slot_regs
    import cdet_pkg::*;
#(
    parameter int              IDX_W    = 6,
    parameter int              DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_WORD  = DATA_W'(32'h4103_4003),
    parameter logic [DATA_W-1:0] DEC_WORD = DATA_W'(32'h11)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              slot_irq,
    output logic              bus_err
);
    localparam logic [DATA_W-1:0] INS_MASK = DATA_W'(1) << INS_POS;
    localparam logic [DATA_W-1:0] WP_MASK  = DATA_W'(1) << WP_POS;

    dec_t              dec;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] sticky;
    logic [DATA_W-1:0] status;

    cdet_decode #(.IDX_W(IDX_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_req),
        .wr    (bus_wr),
        .idx   (bus_idx),
        .dec   (dec),
        .err_o (bus_err)
    );

    // Route the insertion input onto its event bit.
    always_comb set_vec = card_in ? INS_MASK : '0;

    cdet_event #(.DATA_W(DATA_W), .STICKY_MASK(INS_MASK)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_vec),
        .clr_en   (dec.wr_status),
        .clr_data (bus_wdata),
        .sticky   (sticky),
        .pending  (slot_irq)
    );

    // Merge the live write-protect level into the status word.
    always_comb status = sticky | (wp_in ? WP_MASK : '0);

    cdet_rdmux #(.DATA_W(DATA_W), .ID_WORD(ID_WORD), .DEC_WORD(DEC_WORD)) u_rd (
        .dec    (dec),
        .status (status),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/cdet_slot_regs_sva.sv
// Module: property checker for cdet_slot_regs, attached by bind.
module cdet_slot_regs_sva #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [IDX_W-1:0]  bus_idx,
    input logic              clr_bit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wp_in,
    input logic              card_in,
    input logic              slot_irq,
    input logic              bus_err
);
    logic ack_wr;
    logic rd2;
    logic oob;

    always_comb begin
        ack_wr = bus_req && bus_wr && (bus_idx == IDX_W'(2)) && clr_bit;
        rd2    = bus_req && !bus_wr && (bus_idx == IDX_W'(2));
        oob    = bus_req && (bus_idx > IDX_W'(3));
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!slot_irq && !bus_err));

    assert_ident_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && bus_idx == IDX_W'(0)) |-> bus_rdata == DATA_W'(32'h4103_4003));

    assert_wp_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd2 |-> bus_rdata[0] == wp_in);

    assert_insert_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_in |=> slot_irq);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !card_in) |=> !slot_irq);

    assert_irq_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && !card_in) |=> $stable(slot_irq));

    assert_oob_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oob && !bus_wr) |-> bus_rdata == '0);

    assert_oob_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oob |=> bus_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    assert_irq_matches_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd2 |-> bus_rdata[3] == slot_irq);
endmodule

bind cdet_slot_regs cdet_slot_regs_sva #(.IDX_W(IDX_W), .DATA_W(DATA_W)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_idx   (bus_idx),
    .clr_bit   (bus_wdata[3]),
    .bus_rdata (bus_rdata),
    .wp_in     (wp_in),
    .card_in   (card_in),
    .slot_irq  (slot_irq),
    .bus_err   (bus_err)
);

// File: tb/cdet_slot_regs_tb_top.sv
// Bench: table-driven walk of the register map, then directed reset/corner tests.
module cdet_slot_regs_tb_top;
    localparam int IDX_W  = 6;
    localparam int DATA_W = 32;
    localparam logic [31:0] ID_W  = 32'h4103_4003;
    localparam logic [31:0] DEC_W = 32'h0000_0011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_wr = 1'b0;
    logic [IDX_W-1:0]  bus_idx = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wp_in = 1'b0;
    logic              card_in = 1'b0;
    logic              slot_irq;
    logic              bus_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cdet_slot_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_in(wp_in), .card_in(card_in), .slot_irq(slot_irq), .bus_err(bus_err)
    );

    typedef struct packed {
        logic [7:0]  rq;     // requirement number, for messages
        logic        req;
        logic        wr;
        logic [5:0]  idx;
        logic [31:0] wd;
        logic        wp;
        logic        cd;
        logic [31:0] exp_rd;  // read data in the drive cycle
        logic        exp_irq; // after the edge
        logic        exp_err; // after the edge
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'd2,  1'b1, 1'b0, 6'd0, 32'h0,        1'b0, 1'b0, ID_W,        1'b0, 1'b0}, // R2 ident
        '{8'd2,  1'b1, 1'b0, 6'd1, 32'h0,        1'b0, 1'b0, 32'h0,       1'b0, 1'b0}, // R2 flash word
        '{8'd2,  1'b1, 1'b0, 6'd3, 32'h0,        1'b0, 1'b0, DEC_W,       1'b0, 1'b0}, // R2 decode
        '{8'd3,  1'b1, 1'b0, 6'd2, 32'h0,        1'b1, 1'b0, 32'h1,       1'b0, 1'b0}, // R3 wp high
        '{8'd3,  1'b1, 1'b0, 6'd2, 32'h0,        1'b0, 1'b0, 32'h0,       1'b0, 1'b0}, // R3 wp low
        '{8'd4,  1'b0, 1'b0, 6'd0, 32'h0,        1'b0, 1'b1, 32'h0,       1'b1, 1'b0}, // R4 insert
        '{8'd4,  1'b1, 1'b0, 6'd2, 32'h0,        1'b1, 1'b0, 32'h9,       1'b1, 1'b0}, // R4 held
        '{8'd6,  1'b1, 1'b1, 6'd2, 32'hFFFF_FFF7, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0}, // R6 other bits
        '{8'd6,  1'b1, 1'b0, 6'd2, 32'h0,        1'b0, 1'b0, 32'h8,       1'b1, 1'b0}, // R6 readback
        '{8'd7,  1'b1, 1'b1, 6'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0}, // R7 flash write
        '{8'd7,  1'b1, 1'b1, 6'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,      1'b1, 1'b0}, // R7 decode write
        '{8'd7,  1'b1, 1'b0, 6'd3, 32'h0,        1'b0, 1'b0, DEC_W,       1'b1, 1'b0}, // R7 decode intact
        '{8'd5,  1'b1, 1'b1, 6'd2, 32'h8,        1'b0, 1'b0, 32'h0,       1'b0, 1'b0}, // R5 ack
        '{8'd5,  1'b1, 1'b0, 6'd2, 32'h0,        1'b0, 1'b0, 32'h0,       1'b0, 1'b0}, // R5 cleared
        '{8'd8,  1'b1, 1'b1, 6'd2, 32'h8,        1'b0, 1'b1, 32'h0,       1'b1, 1'b0}, // R8 set wins
        '{8'd10, 1'b1, 1'b0, 6'd2, 32'h0,        1'b0, 1'b0, 32'h8,       1'b1, 1'b0}, // R10 bit3 = irq
        '{8'd5,  1'b1, 1'b1, 6'd2, 32'h8,        1'b0, 1'b0, 32'h0,       1'b0, 1'b0}, // R5 ack again
        '{8'd9,  1'b1, 1'b0, 6'd4, 32'h0,        1'b0, 1'b0, 32'h0,       1'b0, 1'b1}, // R9 oob read
        '{8'd9,  1'b1, 1'b0, 6'd0, 32'h0,        1'b0, 1'b0, ID_W,        1'b0, 1'b1}  // R9 sticky
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic rq, input logic w, input logic [5:0] ix,
                         input logic [31:0] d, input logic wp, input logic cd);
        bus_req = rq; bus_wr = w; bus_idx = ix; bus_wdata = d; wp_in = wp; card_in = cd;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset with card_in high: reset must win (R1).
        card_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        card_in = 1'b0;
        rst_n = 1'b1;
        bus_req = 1'b1; bus_idx = 6'd2;
        #1;
        check("R1 status after reset", bus_rdata, 32'h0);
        check("R1 irq after reset", {31'b0, slot_irq}, 32'h0);
        check("R1 err after reset", {31'b0, bus_err}, 32'h0);
        bus_req = 1'b0;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].req, VEC[i].wr, VEC[i].idx, VEC[i].wd, VEC[i].wp, VEC[i].cd);
            #1;
            check($sformatf("R%0d vec%0d rdata", VEC[i].rq, i), bus_rdata, VEC[i].exp_rd);
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d irq", VEC[i].rq, i), {31'b0, slot_irq}, {31'b0, VEC[i].exp_irq});
            check($sformatf("R%0d vec%0d err", VEC[i].rq, i), {31'b0, bus_err}, {31'b0, VEC[i].exp_err});
        end

        // Directed: insert pending, then reset clears irq and err (R1).
        @(negedge clk);
        drive(1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 1'b1);
        @(negedge clk);
        drive(1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 1'b0);
        check("R4 pending before reset", {31'b0, slot_irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq cleared by reset", {31'b0, slot_irq}, 32'h0);
        check("R1 err cleared by reset", {31'b0, bus_err}, 32'h0);

        // Directed: write at top index sets error (R9).
        drive(1'b1, 1'b1, 6'd63, 32'hFFFF_FFFF, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 1'b0);
        check("R9 err after oob write", {31'b0, bus_err}, 32'h1);
        check("R9 oob write left irq", {31'b0, slot_irq}, 32'h0);

        // Directed: clear write without bit 3 keeps event (R5).
        drive(1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b1, 6'd2, 32'h0000_0007, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b0, 6'd2, 32'h0, 1'b1, 1'b0);
        #1;
        check("R5 write w/o bit3 keeps event", bus_rdata, 32'h9);
        check("R10 irq follows bit3", {31'b0, slot_irq}, {31'b0, bus_rdata[3]});
        bus_req = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule